// File: doc/BRIEF.md
# DisplayPort Source Link Bring-Up Sequencer

This block is a small hardware state machine that takes a DisplayPort source transmitter from power-up to the point where link training can begin. It does this without software. On a start pulse it checks the requested link-rate code. It then performs a fixed series of register writes through a single memory-mapped master port. It holds the PHY in reset, turns the transmitter off, loads the AUX clock divider and the link clock select, and releases the PHY. Next it reads the PHY status word until both lanes report that reset is complete and the PLL reports lock. Only then does it switch the transmitter on. As a last, optional step it clears the hot-plug interrupt mask.

The master port carries one transaction at a time. A strobe, with its address and data, is held until the target returns ready. The status wait is limited by a poll count taken at start. If the status never becomes good, the sequencer gives up with a timeout and leaves the transmitter disabled. A one-cycle done pulse marks a completed bring-up.

Top module: `linkup_seq`

## Requirements
- R1: After reset, busy, done, timeout, rate_err, bus_wr and bus_rd are all 0.
- R2: A start pulse accepted in idle produces these accesses, in this order: write 0x01 to 0x200 (PHY held in reset); write 0x00 to 0x080 (transmitter off); write the AUX divider word to 0x10C; write the link clock select to 0x234; write 0x00 to 0x200 (PHY released); then status reads of 0x280.
- R3: The word written to 0x10C is aux_div zero-extended, and the word written to 0x234 is rate_code zero-extended. Both values are the ones present on the inputs in the cycle of the accepted start; later changes to the inputs have no effect.
- R4: A start with a rate_code other than 1, 3 or 5 causes no bus access and leaves busy at 0. It sets rate_err to 1, and rate_err stays at 1 until a start with a legal code is accepted, which clears it.
- R5: Each access keeps its strobe, address and write data unchanged from cycle to cycle until bus_ready is sampled high at a rising clock edge, and bus_wr and bus_rd are never high together.
- R6: A status read passes when bits [1:0] are both 1 and bit 4 is 1. Reads of 0x280 repeat until one passes, and the transmitter-enable write (0x01 to 0x080) is issued only after a passing read.
- R7: At most max(poll_limit, 1) status reads are made. If none of them passes, timeout is set to 1, no transmitter-enable write is issued, no done pulse occurs, and the block returns to idle. timeout stays at 1 until the next accepted start.
- R8: When hpd_unmask_en is 1 at start, a final write of 0x00 to the interrupt mask address (parameter IRQ_MASK_ADDR, default 0x3A4) follows the transmitter-enable write. When hpd_unmask_en is 0 at start, this write is not issued.
- R9: On completion, done is 1 for exactly one cycle, in the cycle after the last write's handshake, and busy is 0 in that same cycle. busy is 1 from the cycle after an accepted start until then.
- R10: A start pulse while busy is 1 is ignored. The running sequence continues with its original configuration, and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| rate_code | input | 3 | Link rate select code (1, 3 or 5) |
| aux_div | input | 16 | AUX clock divider word |
| hpd_unmask_en | input | 1 | Enable the final hot-plug unmask write |
| poll_limit | input | POLL_W (16) | Maximum number of status reads (0 treated as 1) |
| bus_addr | output | AW (16) | Master address |
| bus_wdata | output | DW (32) | Master write data |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_rdata | input | DW (32) | Read data, valid with ready |
| bus_ready | input | 1 | Transaction completes at an edge where this is high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Status poll exhausted (sticky until next start) |
| rate_err | output | 1 | Illegal rate code rejected (sticky until next start) |

## Verification
The bench drives status words that are only partly good: lanes ready without lock, lock without lanes, and one lane only. A sequencer that checked a subset of the bits would enable the transmitter too early, and the write log would show the 0x080 enable write ahead of the passing read. Timeout is exercised with a limit of four and with a limit of zero. An off-by-one counter would make one read too many or too few, and a wrong exit path would still emit the enable write or a done pulse. The bench also applies illegal rate codes, a second start in the middle of a run with a changed divider, and slow targets with wait states. These catch a block that writes before rejecting the code, restarts or re-latches its configuration while busy, or advances before ready.

// File: rtl/linkup_pkg.sv
package linkup_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PHY_HOLD,
      ST_TX_OFF,
      ST_AUX_DIV,
      ST_LINK_CLK,
      ST_PHY_REL,
      ST_POLL_RD,
      ST_POLL_CHK,
      ST_TX_ON,
      ST_HPD_UNMASK
   } step_t;

   localparam logic [11:0] OFS_PHY_RST  = 12'h200;
   localparam logic [11:0] OFS_TX_EN    = 12'h080;
   localparam logic [11:0] OFS_AUX_DIV  = 12'h10C;
   localparam logic [11:0] OFS_LINK_CLK = 12'h234;
   localparam logic [11:0] OFS_PHY_STAT = 12'h280;

   // lane0 done, lane1 done, pll lock
   localparam logic [4:0]  STAT_GOOD    = 5'b1_0011;

endpackage

// File: rtl/linkup_rate_check.sv
module linkup_rate_check #(
   parameter logic [7:0] RATE_MASK = 8'b0010_1010
) (
   input  logic [2:0] code,
   output logic       legal
);
   always_comb legal = RATE_MASK[code];
endmodule

// File: rtl/linkup_poll_timer.sv
module linkup_poll_timer #(
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic [POLL_W-1:0] limit,
   output logic              expired
);
   localparam logic [POLL_W-1:0] ONE = POLL_W'(1);

   logic [POLL_W-1:0] reads_q;
   logic [POLL_W-1:0] limit_eff;

   always_comb limit_eff = (limit == '0) ? ONE : limit;
   always_comb expired   = (reads_q >= limit_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reads_q <= '0;
      else if (clr)
         reads_q <= '0;
      else if (inc && (reads_q != '1))
         reads_q <= reads_q + ONE;
   end
endmodule

// File: rtl/linkup_step_decode.sv
module linkup_step_decode
   import linkup_pkg::*;
#(
   parameter int             AW            = 16,
   parameter int             DW            = 32,
   parameter logic [AW-1:0]  IRQ_MASK_ADDR = AW'(12'h3A4)
) (
   input  step_t          step,
   input  logic [15:0]    aux_div,
   input  logic [2:0]     rate,
   output logic [AW-1:0]  addr,
   output logic [DW-1:0]  wdata,
   output logic           wr,
   output logic           rd
);
   always_comb begin
      addr  = '0;
      wdata = '0;
      wr    = 1'b0;
      rd    = 1'b0;
      unique case (step)
         ST_PHY_HOLD: begin
            addr = AW'(OFS_PHY_RST); wdata[0] = 1'b1; wr = 1'b1;
         end
         ST_TX_OFF: begin
            addr = AW'(OFS_TX_EN); wr = 1'b1;
         end
         ST_AUX_DIV: begin
            addr = AW'(OFS_AUX_DIV); wdata[15:0] = aux_div; wr = 1'b1;
         end
         ST_LINK_CLK: begin
            addr = AW'(OFS_LINK_CLK); wdata[2:0] = rate; wr = 1'b1;
         end
         ST_PHY_REL: begin
            addr = AW'(OFS_PHY_RST); wr = 1'b1;
         end
         ST_POLL_RD: begin
            addr = AW'(OFS_PHY_STAT); rd = 1'b1;
         end
         ST_TX_ON: begin
            addr = AW'(OFS_TX_EN); wdata[0] = 1'b1; wr = 1'b1;
         end
         ST_HPD_UNMASK: begin
            addr = IRQ_MASK_ADDR; wr = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/linkup_seq.sv
module linkup_seq
   import linkup_pkg::*;
#(
   parameter int            AW            = 16,
   parameter int            DW            = 32,
   parameter int            POLL_W        = 16,
   parameter logic [7:0]    RATE_MASK     = 8'b0010_1010,
   parameter logic [AW-1:0] IRQ_MASK_ADDR = AW'(12'h3A4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        rate_code,
   input  logic [15:0]       aux_div,
   input  logic              hpd_unmask_en,
   input  logic [POLL_W-1:0] poll_limit,
   output logic [AW-1:0]     bus_addr,
   output logic [DW-1:0]     bus_wdata,
   output logic              bus_wr,
   output logic              bus_rd,
   input  logic [DW-1:0]     bus_rdata,
   input  logic              bus_ready,
   output logic              busy,
   output logic              done,
   output logic              timeout,
   output logic              rate_err
);
   localparam logic [DW-1:0] STAT_MASK = DW'(STAT_GOOD);

   if (AW < 12) begin : g_bad_aw
      $error("linkup_seq: AW must be at least 12");
   end
   if (DW < 16) begin : g_bad_dw
      $error("linkup_seq: DW must be at least 16");
   end
   if (POLL_W < 1) begin : g_bad_pw
      $error("linkup_seq: POLL_W must be at least 1");
   end

   step_t             state_q;
   logic [15:0]       div_q;
   logic [2:0]        rate_q;
   logic              hpd_q;
   logic [POLL_W-1:0] limit_q;
   logic [DW-1:0]     status_q;
   logic              pass_q;
   logic              rate_ok;
   logic              ack;
   logic              poll_expired;
   logic              status_good;

   linkup_rate_check #(.RATE_MASK(RATE_MASK)) u_rate (
      .code  (rate_code),
      .legal (rate_ok)
   );

   linkup_step_decode #(.AW(AW), .DW(DW), .IRQ_MASK_ADDR(IRQ_MASK_ADDR)) u_dec (
      .step    (state_q),
      .aux_div (div_q),
      .rate    (rate_q),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .wr      (bus_wr),
      .rd      (bus_rd)
   );

   linkup_poll_timer #(.POLL_W(POLL_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state_q == ST_IDLE),
      .inc     ((state_q == ST_POLL_RD) && ack),
      .limit   (limit_q),
      .expired (poll_expired)
   );

   always_comb ack         = (bus_wr || bus_rd) && bus_ready;
   always_comb status_good = ((status_q & STAT_MASK) == STAT_MASK);
   always_comb busy        = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         div_q    <= '0;
         rate_q   <= '0;
         hpd_q    <= 1'b0;
         limit_q  <= '0;
         status_q <= '0;
         pass_q   <= 1'b0;
         done     <= 1'b0;
         timeout  <= 1'b0;
         rate_err <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               timeout <= 1'b0;
               if (rate_ok) begin
                  div_q    <= aux_div;
                  rate_q   <= rate_code;
                  hpd_q    <= hpd_unmask_en;
                  limit_q  <= poll_limit;
                  pass_q   <= 1'b0;
                  rate_err <= 1'b0;
                  state_q  <= ST_PHY_HOLD;
               end else begin
                  rate_err <= 1'b1;
               end
            end
            ST_PHY_HOLD: if (ack) state_q <= ST_TX_OFF;
            ST_TX_OFF:   if (ack) state_q <= ST_AUX_DIV;
            ST_AUX_DIV:  if (ack) state_q <= ST_LINK_CLK;
            ST_LINK_CLK: if (ack) state_q <= ST_PHY_REL;
            ST_PHY_REL:  if (ack) state_q <= ST_POLL_RD;
            ST_POLL_RD: if (ack) begin
               status_q <= bus_rdata;
               state_q  <= ST_POLL_CHK;
            end
            ST_POLL_CHK: begin
               if (status_good) begin
                  pass_q  <= 1'b1;
                  state_q <= ST_TX_ON;
               end else if (poll_expired) begin
                  timeout <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_POLL_RD;
               end
            end
            ST_TX_ON: if (ack) begin
               if (hpd_q) state_q <= ST_HPD_UNMASK;
               else begin
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_HPD_UNMASK: if (ack) begin
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R5
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));

   // R5
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   // R6
   tx_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(OFS_TX_EN) && bus_wdata[0]) |-> pass_q);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7
   timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> (!busy && !done));

   // R4
   rate_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rate_err |-> !busy);

endmodule

// File: tb/linkup_seq_bench.sv
module linkup_seq_bench;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int PW = 16;
   localparam logic [AW-1:0] IRQA = 16'h03A4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [2:0] rate_code = 3'd1;
   logic [15:0] aux_div = 16'h0000;
   logic hpd_unmask_en = 1'b0;
   logic [PW-1:0] poll_limit = 16'd16;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic bus_wr, bus_rd;
   logic [DW-1:0] bus_rdata = '0;
   logic bus_ready = 1'b0;
   logic busy, done, timeout, rate_err;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // bus model state
   int ready_wait = 0;
   int wcnt = 0;
   int nlog = 0;
   int nreads = 0;
   bit           log_wr [32];
   logic [AW-1:0] log_a  [32];
   logic [DW-1:0] log_d  [32];
   logic [DW-1:0] script [8];
   int script_len = 0;
   logic [DW-1:0] stat_final = 32'h13;
   int done_seen = 0;

   always #4 clk = ~clk;

   linkup_seq u_linkup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .rate_code(rate_code),
      .aux_div(aux_div), .hpd_unmask_en(hpd_unmask_en), .poll_limit(poll_limit),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy), .done(done),
      .timeout(timeout), .rate_err(rate_err)
   );

   // behavioural register target, acts on falling edges
   always @(negedge clk) begin
      if (done) done_seen = done_seen + 1;
      if (bus_ready) begin
         bus_ready = 1'b0;
         wcnt = 0;
      end else if (bus_wr || bus_rd) begin
         if (wcnt >= ready_wait) begin
            bus_ready = 1'b1;
            if (nlog < 32) begin
               log_wr[nlog] = bus_wr;
               log_a[nlog]  = bus_addr;
               log_d[nlog]  = bus_wdata;
            end
            nlog = nlog + 1;
            if (bus_rd) begin
               bus_rdata = (nreads < script_len) ? script[nreads] : stat_final;
               nreads = nreads + 1;
            end
         end else begin
            wcnt = wcnt + 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic clear_log();
      nlog = 0; nreads = 0; done_seen = 0; script_len = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 3000) begin
         @(negedge clk); n++;
      end
      check(n < 3000, "watchdog wait_idle", 64'(n), 64'd3000);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_entry(input int i, input bit wr, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input string tag);
      check(log_wr[i] == wr && log_a[i] == a && (!wr || log_d[i] == d), tag,
            {31'(log_a[i]), log_wr[i], log_d[i]}, {31'(a), wr, d});
   endtask

   task automatic check_prefix(input logic [15:0] div, input logic [2:0] rate, input string tag);
      check_entry(0, 1, 16'h200, 32'h1, {tag, " R2 phy hold"});
      check_entry(1, 1, 16'h080, 32'h0, {tag, " R2 tx off"});
      check_entry(2, 1, 16'h10C, 32'(div), {tag, " R3 aux div"});
      check_entry(3, 1, 16'h234, 32'(rate), {tag, " R3 link clk"});
      check_entry(4, 1, 16'h200, 32'h0, {tag, " R2 phy release"});
   endtask

   task automatic t_reset();
      check(!busy && !done && !timeout && !rate_err && !bus_wr && !bus_rd, "R1 reset outputs",
            64'({busy, done, timeout, rate_err, bus_wr, bus_rd}), 64'd0);
   endtask

   task automatic t_normal();
      clear_log();
      rate_code = 3'd1; aux_div = 16'hA55A; hpd_unmask_en = 1'b1; poll_limit = 16;
      pulse_start();
      check(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
      wait_idle();
      check(nlog == 8, "R2 access count normal", 64'(nlog), 64'd8);
      check_prefix(16'hA55A, 3'd1, "normal");
      check_entry(5, 0, 16'h280, 32'h0, "normal R6 status read");
      check_entry(6, 1, 16'h080, 32'h1, "normal R6 tx on");
      check_entry(7, 1, IRQA, 32'h0, "normal R8 unmask");
      check(done_seen == 1, "R9 done one cycle", 64'(done_seen), 64'd1);
      check(!timeout && !rate_err, "R7 no timeout on pass", 64'({timeout, rate_err}), 64'd0);
   endtask

   task automatic t_no_hpd_waits();
      clear_log();
      ready_wait = 3;
      rate_code = 3'd5; aux_div = 16'h1234; hpd_unmask_en = 1'b0;
      pulse_start();
      wait_idle();
      ready_wait = 0;
      check(nlog == 7, "R8 no unmask write count", 64'(nlog), 64'd7);
      check_prefix(16'h1234, 3'd5, "waits");
      check_entry(6, 1, 16'h080, 32'h1, "waits R5 tx on last");
      check(done_seen == 1, "R9 done with waits", 64'(done_seen), 64'd1);
   endtask

   task automatic t_partial_status();
      clear_log();
      script[0] = 32'h03; script[1] = 32'h11; script[2] = 32'h12; script[3] = 32'h01;
      script_len = 4;
      rate_code = 3'd3; aux_div = 16'h00FF; hpd_unmask_en = 1'b1; poll_limit = 16;
      pulse_start();
      wait_idle();
      check(nlog == 12, "R6 partial status access count", 64'(nlog), 64'd12);
      check(nreads == 5, "R6 reads until pass", 64'(nreads), 64'd5);
      check_prefix(16'h00FF, 3'd3, "partial");
      for (int i = 5; i < 10; i++) check_entry(i, 0, 16'h280, 32'h0, "partial R6 poll read");
      check_entry(10, 1, 16'h080, 32'h1, "partial R6 tx on after pass");
      check_entry(11, 1, IRQA, 32'h0, "partial R8 unmask");
   endtask

   task automatic t_timeout(input logic [PW-1:0] lim, input int exp_reads);
      clear_log();
      stat_final = 32'h03;
      rate_code = 3'd1; aux_div = 16'h0042; hpd_unmask_en = 1'b1; poll_limit = lim;
      pulse_start();
      wait_idle();
      check(nreads == exp_reads, "R7 bounded read count", 64'(nreads), 64'(exp_reads));
      check(nlog == 5 + exp_reads, "R7 no tx enable write", 64'(nlog), 64'(5 + exp_reads));
      check(timeout == 1'b1 && !busy, "R7 timeout set idle", 64'({timeout, busy}), 64'b10);
      check(done_seen == 0, "R7 no done on timeout", 64'(done_seen), 64'd0);
      stat_final = 32'h13;
   endtask

   task automatic t_bad_rate(input logic [2:0] code);
      clear_log();
      rate_code = code;
      pulse_start();
      repeat (10) @(negedge clk);
      check(nlog == 0 && !busy, "R4 no access on illegal code", 64'({nlog[7:0], busy}), 64'd0);
      check(rate_err == 1'b1, "R4 rate_err set", 64'(rate_err), 64'd1);
      check(timeout == 1'b0, "R7 timeout cleared by start", 64'(timeout), 64'd0);
   endtask

   task automatic t_busy_start();
      clear_log();
      rate_code = 3'd3; aux_div = 16'hBEEF; hpd_unmask_en = 1'b1; poll_limit = 16;
      pulse_start();
      check(rate_err == 1'b0, "R4 rate_err cleared by legal start", 64'(rate_err), 64'd0);
      repeat (3) @(negedge clk);
      aux_div = 16'h0101; rate_code = 3'd5; hpd_unmask_en = 1'b0;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_idle();
      repeat (5) @(negedge clk);
      check(nlog == 8, "R10 single sequence", 64'(nlog), 64'd8);
      check_prefix(16'hBEEF, 3'd3, "busy R10 R3 latched");
      check_entry(7, 1, IRQA, 32'h0, "busy R10 unmask kept");
      check(done_seen == 1, "R10 one done", 64'(done_seen), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_normal();
      t_no_hpd_waits();
      t_partial_status();
      t_timeout(16'd4, 4);
      t_bad_rate(3'd2);
      t_timeout(16'd0, 1);
      t_bad_rate(3'd0);
      t_bad_rate(3'd7);
      t_busy_start();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule